// File: doc/BRIEF.md
# Two-Lane Random Linear Network Coder

This block sits between two payload queues and a packing stage. Each queue presents a payload stream of 64-bit words. Every word comes with an 8-bit control byte and an empty flag, and a word is consumed with a read strobe. When the block is idle and both queues hold data, it starts a coded packet. It draws two fresh nonzero 8-bit coefficients from a pseudo-random generator. For each pair of words it then forms `data_a*coef_a + data_b*coef_b` as an unsigned 72-bit value. The stream of 72-bit results is repacked onto a 64-bit bus. When only one queue holds data, that packet is copied to the output unchanged.

Each output word is 73 bits wide: `[63:0]` data, `[64]` coded flag, `[72:65]` control byte. The two coefficients of the most recent coded packet are held on output ports, so the packing stage can store them in the packet header. A 3-bit mode port tells the packing stage what the block is doing.

Top module: `rlnc_coder`

## Requirements
- R1: In idle, if both queues are non-empty the block enters a coded packet. If only queue A is non-empty it forwards A uncoded; if only queue B is non-empty it forwards B. A queue that fills later waits until the current packet is finished.
- R2: An uncoded word appears unchanged on the output, with data in `[63:0]`, flag bit 64 at 0 and the input control byte in `[72:65]`. An uncoded packet ends with the first word whose control byte is nonzero.
- R3: The coefficient generator is a 16-bit shift register. On each step it shifts left and inserts bit15^bit13^bit12^bit10, and it restarts from 16'hACE1 at reset. Each coded packet takes two steps: `coef_a` is the low byte after the first step and `coef_b` the low byte after the second, and a zero byte is replaced by 1. Both coefficients stay constant until the next coded packet.
- R4: Each coded 72-bit value is `data_a*coef_a + data_b*coef_b`, computed unsigned and kept modulo 2^72.
- R5: The coded values are concatenated with the first value in the least significant bits and sent as 64-bit slices, lowest first. The last slice is zero-filled. A coded packet of N pairs gives ceil(72N/64) words, all with bit 64 at 1. The control byte is 8'h01 on the last word of the packet and 8'h00 on all other words.
- R6: A coded packet ends on the first read pair in which both control bytes are nonzero. A nonzero byte is either an end mark or the padding mark 8'hF0, so a shorter packet padded by the upstream stage remains paired to the end.
- R7: An output write (`out_wr_en` high) occurs only in the cycle after a cycle in which `out_ready` was high.
- R8: `mode` reports 0 idle, 1 coefficient draw, 2 coding, 3 draining the repacker, 4 forwarding A, 5 forwarding B. It never takes any other value.
- R9: While reset is held, `out_wr_en`, both read strobes, `mode`, both coefficients and `out_word` are all zero.
- R10: A read strobe is never raised while its queue reports empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_data | input | 64 | Queue A head word, valid while `a_empty` is low |
| a_ctrl | input | 8 | Queue A head control byte |
| a_empty | input | 1 | Queue A has no word |
| a_rd_en | output | 1 | Consume queue A head word this cycle |
| b_data | input | 64 | Queue B head word |
| b_ctrl | input | 8 | Queue B head control byte |
| b_empty | input | 1 | Queue B has no word |
| b_rd_en | output | 1 | Consume queue B head word this cycle |
| out_ready | input | 1 | Downstream can take a word in the next cycle |
| out_wr_en | output | 1 | `out_word` is written this cycle |
| out_word | output | 73 | Control byte, coded flag, data |
| coef_a | output | 8 | Coefficient applied to queue A |
| coef_b | output | 8 | Coefficient applied to queue B |
| mode | output | 3 | Current operating mode |

## Verification
Coded packets of eight pairs fill the repacker exactly, with no flush word. Packets of one and five pairs leave a partial slice, which separates a correct zero-filled flush from a dropped or duplicated tail. A padded packet, with one side's end mark followed by 8'hF0 words, checks that the pair is not closed early. All-ones data forces the 72-bit sum to wrap, and bursty `out_ready` patterns expose lost or repeated slices. Single-queue packets on each side and a second queue filling one cycle too late show that the mode decision depends on occupancy at idle. A reset followed by a fresh coded packet shows that the coefficient sequence starts again from the seed.

// File: rtl/rlnc_pkg.sv
package rlnc_pkg;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_DRAW   = 3'd1,
    M_CODED  = 3'd2,
    M_FLUSH  = 3'd3,
    M_PASS_A = 3'd4,
    M_PASS_B = 3'd5
  } mode_e;

  localparam int unsigned LFSR_W = 16;

  // Maximal-length Fibonacci step, taps 16,14,13,11 (1-based)
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/rlnc_coef_gen.sv
module rlnc_coef_gen
  import rlnc_pkg::*;
#(
  parameter int unsigned       COEF_W = 8,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              draw,
  output logic [COEF_W-1:0] coef_a,
  output logic [COEF_W-1:0] coef_b
);

  logic [LFSR_W-1:0] lfsr_q, lfsr_d, step1, step2;
  logic [COEF_W-1:0] ca_q, ca_d, cb_q, cb_d;

  function automatic logic [COEF_W-1:0] nonzero(input logic [LFSR_W-1:0] s);
    logic [COEF_W-1:0] v;
    v = s[COEF_W-1:0];
    return (v == '0) ? COEF_W'(1) : v;
  endfunction

  always_comb begin
    step1  = lfsr_next(lfsr_q);
    step2  = lfsr_next(step1);
    lfsr_d = lfsr_q;
    ca_d   = ca_q;
    cb_d   = cb_q;
    if (draw) begin
      lfsr_d = step2;
      ca_d   = nonzero(step1);
      cb_d   = nonzero(step2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      ca_q   <= '0;
      cb_q   <= '0;
    end else if (draw) begin
      lfsr_q <= lfsr_d;
      ca_q   <= ca_d;
      cb_q   <= cb_d;
    end
  end

  assign coef_a = ca_q;
  assign coef_b = cb_q;

endmodule

// File: rtl/rlnc_mac.sv
module rlnc_mac #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         load_last,
  input  logic [LANES-1:0][DATA_W-1:0] lane_data,
  input  logic [LANES-1:0][COEF_W-1:0] lane_coef,
  input  logic                         take,
  output logic                         can_load,
  output logic                         res_valid,
  output logic [PROD_W-1:0]            res_word,
  output logic                         res_last
);

  logic [LANES-1:0][PROD_W-1:0] prod;
  logic [PROD_W-1:0]            sum;
  logic                         valid_q, valid_d, last_q, last_d;
  logic [PROD_W-1:0]            word_q, word_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign prod[g] = PROD_W'(lane_data[g]) * PROD_W'(lane_coef[g]);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) sum = sum + prod[i];
  end

  always_comb begin
    valid_d = valid_q;
    word_d  = word_q;
    last_d  = last_q;
    if (load) begin
      valid_d = 1'b1;
      word_d  = sum;
      last_d  = load_last;
    end else if (take) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load) begin
        word_q <= word_d;
        last_q <= last_d;
      end
    end
  end

  assign can_load  = !valid_q || take;
  assign res_valid = valid_q;
  assign res_word  = word_q;
  assign res_last  = last_q;

endmodule

// File: rtl/rlnc_repack.sv
module rlnc_repack #(
  parameter int unsigned IN_W  = 72,
  parameter int unsigned OUT_W = 64,
  localparam int unsigned ACC_W = IN_W + OUT_W,
  localparam int unsigned CNT_W = $clog2(ACC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_word,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             emit_en,
  output logic             emit,
  output logic [OUT_W-1:0] emit_word,
  output logic             emit_last,
  output logic             busy
);

  localparam logic [CNT_W-1:0] OUT_CNT = CNT_W'(OUT_W);
  localparam logic [CNT_W-1:0] IN_CNT  = CNT_W'(IN_W);

  logic [ACC_W-1:0] acc_q, acc_d, acc_e;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_e;
  logic             pend_q, pend_d;
  logic             accept;

  always_comb begin
    emit      = emit_en && ((cnt_q >= OUT_CNT) || (pend_q && cnt_q != '0));
    emit_last = pend_q && (cnt_q <= OUT_CNT);
    emit_word = acc_q[OUT_W-1:0];
    acc_e     = acc_q;
    cnt_e     = cnt_q;
    if (emit) begin
      acc_e = acc_q >> OUT_W;
      cnt_e = (cnt_q >= OUT_CNT) ? (cnt_q - OUT_CNT) : '0;
    end
    in_ready = !pend_q && (cnt_e < OUT_CNT);
    accept   = in_valid && in_ready;
    acc_d    = acc_e;
    cnt_d    = cnt_e;
    pend_d   = pend_q;
    if (accept) begin
      acc_d = acc_e | (ACC_W'(in_word) << cnt_e);
      cnt_d = cnt_e + IN_CNT;
      if (in_last) pend_d = 1'b1;
    end else if (emit && emit_last) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign busy = pend_q || (cnt_q != '0);

endmodule

// File: rtl/rlnc_coder.sv
module rlnc_coder
  import rlnc_pkg::*;
#(
  parameter int unsigned       DATA_W    = 64,
  parameter int unsigned       CTRL_W    = 8,
  parameter int unsigned       COEF_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int unsigned PROD_W = DATA_W + COEF_W,
  localparam int unsigned WORD_W = CTRL_W + 1 + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_data,
  input  logic [CTRL_W-1:0] a_ctrl,
  input  logic              a_empty,
  output logic              a_rd_en,
  input  logic [DATA_W-1:0] b_data,
  input  logic [CTRL_W-1:0] b_ctrl,
  input  logic              b_empty,
  output logic              b_rd_en,
  input  logic              out_ready,
  output logic              out_wr_en,
  output logic [WORD_W-1:0] out_word,
  output logic [COEF_W-1:0] coef_a,
  output logic [COEF_W-1:0] coef_b,
  output logic [2:0]        mode
);

  localparam logic [CTRL_W-1:0] END_MARK = CTRL_W'(1);

  mode_e state_q, state_d;

  logic              both_avail, pair_final;
  logic              coded_rd, pass_rd_a, pass_rd_b, draw;
  logic              mac_can_load, mac_valid, mac_last;
  logic [PROD_W-1:0] mac_word;
  logic              rp_ready, rp_emit, rp_last, rp_busy;
  logic [DATA_W-1:0] rp_word;
  logic [WORD_W-1:0] out_q, out_d;
  logic              wr_q, wr_d;

  // ---------------- mode sequencing
  always_comb begin
    both_avail = !a_empty && !b_empty;
    pair_final = (a_ctrl != '0) && (b_ctrl != '0);
    coded_rd   = (state_q == M_CODED) && both_avail && mac_can_load;
    pass_rd_a  = (state_q == M_PASS_A) && !a_empty && out_ready;
    pass_rd_b  = (state_q == M_PASS_B) && !b_empty && out_ready;
    draw       = (state_q == M_DRAW);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      M_IDLE: begin
        if (both_avail)    state_d = M_DRAW;
        else if (!a_empty) state_d = M_PASS_A;
        else if (!b_empty) state_d = M_PASS_B;
      end
      M_DRAW:   state_d = M_CODED;
      M_CODED:  if (coded_rd && pair_final) state_d = M_FLUSH;
      M_FLUSH:  if (!mac_valid && !rp_busy) state_d = M_IDLE;
      M_PASS_A: if (pass_rd_a && a_ctrl != '0) state_d = M_IDLE;
      M_PASS_B: if (pass_rd_b && b_ctrl != '0) state_d = M_IDLE;
      default:  state_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= M_IDLE;
    else        state_q <= state_d;
  end

  assign a_rd_en = coded_rd || pass_rd_a;
  assign b_rd_en = coded_rd || pass_rd_b;
  assign mode    = state_q;

  // ---------------- coefficient source
  rlnc_coef_gen #(
    .COEF_W (COEF_W),
    .SEED   (LFSR_SEED)
  ) u_coef (
    .clk    (clk),
    .rst_n  (rst_n),
    .draw   (draw),
    .coef_a (coef_a),
    .coef_b (coef_b)
  );

  // ---------------- multiply-accumulate stage
  rlnc_mac #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .LANES  (2)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (coded_rd),
    .load_last (pair_final),
    .lane_data ({b_data, a_data}),
    .lane_coef ({coef_b, coef_a}),
    .take      (rp_ready),
    .can_load  (mac_can_load),
    .res_valid (mac_valid),
    .res_word  (mac_word),
    .res_last  (mac_last)
  );

  // ---------------- width conversion
  rlnc_repack #(
    .IN_W  (PROD_W),
    .OUT_W (DATA_W)
  ) u_repack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mac_valid),
    .in_word   (mac_word),
    .in_last   (mac_last),
    .in_ready  (rp_ready),
    .emit_en   (out_ready),
    .emit      (rp_emit),
    .emit_word (rp_word),
    .emit_last (rp_last),
    .busy      (rp_busy)
  );

  // ---------------- output register
  always_comb begin
    out_d = out_q;
    wr_d  = 1'b0;
    if (rp_emit) begin
      wr_d  = 1'b1;
      out_d = {(rp_last ? END_MARK : '0), 1'b1, rp_word};
    end else if (pass_rd_a) begin
      wr_d  = 1'b1;
      out_d = {a_ctrl, 1'b0, a_data};
    end else if (pass_rd_b) begin
      wr_d  = 1'b1;
      out_d = {b_ctrl, 1'b0, b_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= wr_d;
      if (wr_d) out_q <= out_d;
    end
  end

  assign out_wr_en = wr_q;
  assign out_word  = out_q;

endmodule

// File: rtl/rlnc_coder_chk.sv
module rlnc_coder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        a_empty,
  input logic        b_empty,
  input logic        a_rd_en,
  input logic        b_rd_en,
  input logic        out_ready,
  input logic        out_wr_en,
  input logic [72:0] out_word,
  input logic [7:0]  coef_a,
  input logic [7:0]  coef_b,
  input logic [2:0]  mode
);

  a_r10_no_read_empty_a: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd_en |-> !a_empty);

  a_r10_no_read_empty_b: assert property (@(posedge clk) disable iff (!rst_n)
    b_rd_en |-> !b_empty);

  a_r7_write_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> $past(out_ready));

  a_r3_coef_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (coef_a != 8'd0 && coef_b != 8'd0));

  a_r3_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && $past(mode) == 3'd2) |-> ($stable(coef_a) && $stable(coef_b)));

  a_r1_draw_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> $past(!a_empty && !b_empty));

  a_r2_uncoded_from_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr_en && !out_word[64]) |-> $past(mode == 3'd4 || mode == 3'd5));

  a_r8_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd5);

endmodule

bind rlnc_coder rlnc_coder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_empty   (a_empty),
  .b_empty   (b_empty),
  .a_rd_en   (a_rd_en),
  .b_rd_en   (b_rd_en),
  .out_ready (out_ready),
  .out_wr_en (out_wr_en),
  .out_word  (out_word),
  .coef_a    (coef_a),
  .coef_b    (coef_b),
  .mode      (mode)
);

// File: tb/rlnc_coder_bench.sv
`timescale 1ns/1ps
module rlnc_coder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] a_data, b_data;
  logic [7:0]  a_ctrl, b_ctrl;
  logic        a_empty, b_empty, a_rd_en, b_rd_en;
  logic        out_ready, out_wr_en;
  logic [72:0] out_word;
  logic [7:0]  coef_a, coef_b;
  logic [2:0]  mode;

  always #5 clk = ~clk;

  rlnc_coder u_rlnc_coder (
    .clk(clk), .rst_n(rst_n),
    .a_data(a_data), .a_ctrl(a_ctrl), .a_empty(a_empty), .a_rd_en(a_rd_en),
    .b_data(b_data), .b_ctrl(b_ctrl), .b_empty(b_empty), .b_rd_en(b_rd_en),
    .out_ready(out_ready), .out_wr_en(out_wr_en), .out_word(out_word),
    .coef_a(coef_a), .coef_b(coef_b), .mode(mode)
  );

  // show-ahead queue models
  logic [63:0] mem_ad [64];
  logic [7:0]  mem_ac [64];
  logic [63:0] mem_bd [64];
  logic [7:0]  mem_bc [64];
  logic [5:0]  wp_a = '0, rp_a = '0, wp_b = '0, rp_b = '0;

  assign a_empty = (wp_a == rp_a);
  assign b_empty = (wp_b == rp_b);
  assign a_data  = mem_ad[rp_a];
  assign a_ctrl  = mem_ac[rp_a];
  assign b_data  = mem_bd[rp_b];
  assign b_ctrl  = mem_bc[rp_b];

  always @(posedge clk) begin
    if (a_rd_en) rp_a <= rp_a + 6'd1;
    if (b_rd_en) rp_b <= rp_b + 6'd1;
  end

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [72:0] exp_w [16];
  logic [72:0] got_w [16];
  int          exp_n, got_n;
  logic [15:0] mdl_lfsr;
  bit          saw_mode [8];

  // kind[33:32] 0=coded 1=coded padded 2=only A 3=only B, len, short len, ready pattern, data seed
  localparam logic [33:0] VECS [8] = '{
    {2'd0, 4'd8, 4'd0, 8'hFF,        16'h1234},
    {2'd0, 4'd1, 4'd0, 8'hFF,        16'hBEEF},
    {2'd1, 4'd3, 4'd2, 8'hFF,        16'h0F0F},
    {2'd2, 4'd4, 4'd0, 8'hFF,        16'h5555},
    {2'd3, 4'd2, 4'd0, 8'hFF,        16'h7A7A},
    {2'd0, 4'd8, 4'd0, 8'b10110010,  16'hC001},
    {2'd0, 4'd5, 4'd0, 8'b01011010,  16'hFFFF},
    {2'd2, 4'd3, 4'd0, 8'b10000001,  16'h2468}
  };

  function automatic logic [15:0] mdl_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [7:0] mdl_coef(input logic [15:0] s);
    return (s[7:0] == 8'd0) ? 8'd1 : s[7:0];
  endfunction

  function automatic logic [63:0] mkdata(input logic [15:0] seed, input int i);
    logic [63:0] b;
    int r;
    b = {4{seed}};
    r = (i * 13) % 64;
    return (r == 0) ? b : ((b << r) | (b >> (64 - r)));
  endfunction

  task automatic check(input bit ok, input string req, input logic [72:0] act, input logic [72:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic collect(input logic [7:0] rdy);
    int cyc;
    got_n = 0;
    cyc   = 0;
    for (int i = 0; i < 8; i++) saw_mode[i] = 0;
    while ((got_n < exp_n || mode != 3'd0 || !a_empty || !b_empty) && cyc < 800) begin
      @(negedge clk);
      saw_mode[mode] = 1;
      if (out_wr_en) begin
        if (got_n < 16) got_w[got_n] = out_word;
        got_n++;
      end
      out_ready = rdy[cyc % 8];
      cyc++;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (out_wr_en) got_n++;
    end
    out_ready = 1'b1;
  endtask

  task automatic run_vec(input logic [33:0] v);
    logic [1:0]   kind;
    int           len, shrt;
    logic [7:0]   rdy;
    logic [15:0]  seed, s1, s2;
    logic [63:0]  da [8];
    logic [63:0]  db [8];
    logic [7:0]   ca_t [8];
    logic [7:0]   cb_t [8];
    logic [7:0]   ka, kb;
    logic [575:0] stream;
    logic [71:0]  sum;
    string        tag;
    kind = v[33:32]; len = int'(v[31:28]); shrt = int'(v[27:24]);
    rdy  = v[23:16]; seed = v[15:0];
    ka = 8'd0; kb = 8'd0;
    for (int i = 0; i < 8; i++) begin
      da[i] = mkdata(seed, i);
      db[i] = mkdata(seed ^ 16'h3C3C, i + 3);
      ca_t[i] = (i == len - 1) ? ((kind == 2'd2) ? 8'h02 : 8'h01) : 8'h00;
      cb_t[i] = (i == len - 1) ? ((kind == 2'd3) ? 8'h08 : 8'h10) : 8'h00;
      if (kind == 2'd1) begin
        cb_t[i] = (i == len - 1) ? 8'h04 : 8'h00;
        if (i == shrt - 1) ca_t[i] = 8'h80;
        else if (i >= shrt) begin ca_t[i] = 8'hF0; da[i] = 64'd0; end
        else ca_t[i] = 8'h00;
      end
    end
    exp_n = 0;
    if (kind <= 2'd1) begin
      s1 = mdl_step(mdl_lfsr); s2 = mdl_step(s1);
      ka = mdl_coef(s1); kb = mdl_coef(s2); mdl_lfsr = s2;
      stream = '0;
      for (int k = 0; k < len; k++) begin
        sum = 72'(da[k]) * 72'(ka) + 72'(db[k]) * 72'(kb);
        stream[k*72 +: 72] = sum;
      end
      exp_n = (72 * len + 63) / 64;
      for (int j = 0; j < exp_n; j++)
        exp_w[j] = {(j == exp_n - 1) ? 8'h01 : 8'h00, 1'b1, stream[j*64 +: 64]};
    end else begin
      exp_n = len;
      for (int j = 0; j < len; j++)
        exp_w[j] = (kind == 2'd2) ? {ca_t[j], 1'b0, da[j]} : {cb_t[j], 1'b0, db[j]};
    end
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (kind != 2'd3) begin mem_ad[6'(wp_a + 6'(i))] = da[i]; mem_ac[6'(wp_a + 6'(i))] = ca_t[i]; end
      if (kind != 2'd2) begin mem_bd[6'(wp_b + 6'(i))] = db[i]; mem_bc[6'(wp_b + 6'(i))] = cb_t[i]; end
    end
    if (kind != 2'd3) wp_a = wp_a + 6'(len);
    if (kind != 2'd2) wp_b = wp_b + 6'(len);
    collect(rdy);
    tag = (kind == 2'd0) ? "R4 R5 coded" : (kind == 2'd1) ? "R6 R5 padded coded" :
          (kind == 2'd2) ? "R1 R2 pass A" : "R1 R2 pass B";
    check(got_n == exp_n, {tag, " word count"}, 73'(got_n), 73'(exp_n));
    for (int j = 0; j < exp_n && j < 16; j++)
      check(got_w[j] === exp_w[j], {tag, " word"}, got_w[j], exp_w[j]);
    if (kind <= 2'd1) begin
      check(coef_a == ka && coef_b == kb, "R3 coefficients", 73'({coef_a, coef_b}), 73'({ka, kb}));
      check(saw_mode[2] && saw_mode[3], "R8 coded modes seen", 73'({saw_mode[2], saw_mode[3]}), 73'(3));
    end else begin
      check(saw_mode[(kind == 2'd2) ? 4 : 5], "R8 pass mode seen", 73'(0), 73'(1));
    end
  endtask

  task automatic check_reset_state();
    check(out_wr_en == 1'b0 && a_rd_en == 1'b0 && b_rd_en == 1'b0, "R9 strobes in reset",
          73'({out_wr_en, a_rd_en, b_rd_en}), 73'(0));
    check(mode == 3'd0 && coef_a == 8'd0 && coef_b == 8'd0, "R9 mode and coefficients in reset",
          73'({mode, coef_a, coef_b}), 73'(0));
    check(out_word == 73'd0, "R9 output word in reset", out_word, 73'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    out_ready = 1'b1;
    mdl_lfsr  = 16'hACE1;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int vi = 0; vi < 8; vi++) run_vec(VECS[vi]);

    // R1: queue B fills one cycle after A; both go uncoded in order
    @(negedge clk);
    mem_ad[wp_a] = 64'h1111_2222_3333_4444; mem_ac[wp_a] = 8'h00;
    mem_ad[6'(wp_a + 6'd1)] = 64'h5555_6666_7777_8888; mem_ac[6'(wp_a + 6'd1)] = 8'h20;
    wp_a = wp_a + 6'd2;
    @(negedge clk);
    mem_bd[wp_b] = 64'h9999_AAAA_BBBB_CCCC; mem_bc[wp_b] = 8'h00;
    mem_bd[6'(wp_b + 6'd1)] = 64'hDDDD_EEEE_FFFF_0000; mem_bc[6'(wp_b + 6'd1)] = 8'h40;
    wp_b = wp_b + 6'd2;
    exp_n = 4;
    exp_w[0] = {8'h00, 1'b0, 64'h1111_2222_3333_4444};
    exp_w[1] = {8'h20, 1'b0, 64'h5555_6666_7777_8888};
    exp_w[2] = {8'h00, 1'b0, 64'h9999_AAAA_BBBB_CCCC};
    exp_w[3] = {8'h40, 1'b0, 64'hDDDD_EEEE_FFFF_0000};
    collect(8'hFF);
    check(got_n == 4, "R1 staggered arrival count", 73'(got_n), 73'(4));
    for (int j = 0; j < 4; j++)
      check(got_w[j] === exp_w[j], "R1 staggered arrival word", got_w[j], exp_w[j]);

    // R9 then R3: reset mid-run restarts the coefficient sequence
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    mdl_lfsr = 16'hACE1;
    @(negedge clk);
    run_vec({2'd0, 4'd2, 4'd0, 8'hFF, 16'h0BAD});

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule